// File: doc/BRIEF.md
# 4:1:1 Video Sample Packer and Unpacker

This block moves a 4:1:1 component video stream over one 12-bit word per sample clock, and gets it back again. The packer takes an 8-bit luma sample on every clock. It also takes one 8-bit U and one 8-bit V sample per group of four clocks, plus a blanking input. It produces a registered 12-bit bus word. Luma occupies the upper eight bus bits. Each chroma byte is sliced into 2-bit pairs, and one pair goes out on each of the four clocks of the group, on two dedicated lines per chroma component.

The unpacker is a separate path in the same top. It takes a 12-bit word and a blanking flag that is aligned with it. It returns luma with a per-clock valid, and reassembles each U/V byte pair, announcing it with a single-clock strobe. Blanking resets the four-clock group phase on both sides, so every active line starts a fresh chroma group. Placing the packer's output directly into the unpacker loses no data.

Top module: `vid411_codec`

## Requirements
- R1: Bus bits 11..4 equal the luma input of the previous clock whenever blanking was low on that clock.
- R2: Bus bit 3 carries the odd-numbered U bits and bit 2 the even-numbered U bits; bit 1 and bit 0 carry the odd and even V bits in the same way.
- R3: Over the four clocks of a group, the chroma pairs leave in the order bits (7,6), (5,4), (3,2), (1,0).
- R4: U and V are sampled only on the first clock of a group; changes on the other three clocks have no effect on the bus.
- R5: Blanking resets the group phase, so the first active clock after blanking carries chroma bits 7 and 6 of the U and V sampled on that clock.
- R6: For a clock with blanking high, the next bus word is 0x10A (luma 16, chroma lanes 1,0,1,0 = top pair of the black level 128), and the bus blanking output is high.
- R7: The unpacker outputs bus bits 11..4 as luma one clock after the word, with luma valid high exactly when that word's blanking flag was low.
- R8: One clock after the fourth active word of a group, the unpacker raises chroma valid for exactly one clock and presents the reassembled U and V bytes.
- R9: A group cut short by blanking produces no chroma valid pulse.
- R10: Feeding the packer output into the unpacker returns the same luma and the U/V bytes sampled at each group start.
- R11: After reset, the bus word is 0x10A, bus blanking is high, and both unpacker valids are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| pk_y | input | 8 | Luma sample to pack, every clock |
| pk_u | input | 8 | U sample, taken at group start |
| pk_v | input | 8 | V sample, taken at group start |
| pk_blank | input | 1 | Blanking; resets group phase |
| pk_bus | output | 12 | Packed word, registered |
| pk_bus_blank | output | 1 | Blanking flag aligned with pk_bus |
| up_bus | input | 12 | Packed word to unpack |
| up_blank | input | 1 | Blanking flag aligned with up_bus |
| up_y | output | 8 | Recovered luma |
| up_y_valid | output | 1 | Luma valid |
| up_u | output | 8 | Recovered U byte |
| up_v | output | 8 | Recovered V byte |
| up_c_valid | output | 1 | One-clock strobe for a complete U/V pair |

## Verification
A long random stream with random luma and chroma on every clock and sparse random blanking exercises lane placement, pair order and loopback recovery at arbitrary group alignments. Directed patterns put set bits only at the top of U and the bottom of V, which separates a lane swap from a pair-order reversal. Chroma that changes in the middle of a group shows whether sampling happens only at group start. Blanking that cuts a group short after two clocks tells a proper phase restart and a suppressed strobe apart from a counter that keeps running.

// File: rtl/vid411_pkg.sv
package vid411_pkg;
  // width of a phase counter able to count a group of the given length
  function automatic int ph_width(input int group);
    return (group > 1) ? $clog2(group) : 1;
  endfunction

  localparam int DEF_Y_W = 8;
  localparam int DEF_C_W = 8;
endpackage

// File: rtl/vid411_phase.sv
module vid411_phase
  import vid411_pkg::*;
#(
  parameter int GROUP = 4,
  localparam int PH_W = ph_width(GROUP)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            blank,
  output logic [PH_W-1:0] phase,
  output logic            first,
  output logic            last
);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(GROUP - 1);

  assign first = !blank && (phase == '0);
  assign last  = !blank && (phase == PH_LAST);

  always_ff @(posedge clk) begin
    if (rst || blank || last) phase <= '0;
    else                      phase <= phase + 1'b1;
  end

  // blanking must leave the next clock at group start
  assert_phase_restart_R5: assert property (@(posedge clk) disable iff (rst)
    blank |=> (phase == '0));
endmodule

// File: rtl/vid411_chroma_ser.sv
module vid411_chroma_ser #(
  parameter int C_W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           adv,
  input  logic [C_W-1:0] smp,
  output logic [1:0]     pair
);
  logic [C_W-1:0] hold;

  // pair = {odd bit, even bit}, most significant pair first
  assign pair = load ? smp[C_W-1 -: 2] : hold[C_W-1 -: 2];

  always_ff @(posedge clk) begin
    if (rst)       hold <= '0;
    else if (load) hold <= smp << 2;
    else if (adv)  hold <= hold << 2;
  end
endmodule

// File: rtl/vid411_chroma_des.sv
module vid411_chroma_des #(
  parameter int C_W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           shift_en,
  input  logic [1:0]     pair,
  output logic [C_W-1:0] word
);
  logic [C_W-1:0] acc;

  assign word = {acc[C_W-3:0], pair};

  always_ff @(posedge clk) begin
    if (rst)           acc <= '0;
    else if (shift_en) acc <= word;
  end
endmodule

// File: rtl/vid411_packer.sv
module vid411_packer #(
  parameter int Y_W = 8,
  parameter int C_W = 8,
  parameter logic [Y_W-1:0] Y_BLACK = Y_W'(16),
  parameter logic [C_W-1:0] C_BLACK = C_W'(128),
  localparam int BW = Y_W + 4,
  localparam int GROUP = C_W / 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [Y_W-1:0] in_y,
  input  logic [C_W-1:0] in_u,
  input  logic [C_W-1:0] in_v,
  input  logic           in_blank,
  output logic [BW-1:0]  bus_o,
  output logic           bus_blank_o
);
  localparam logic [BW-1:0] BLACK_WORD =
    {Y_BLACK, C_BLACK[C_W-1 -: 2], C_BLACK[C_W-1 -: 2]};

  logic first, last;
  logic [vid411_pkg::ph_width(GROUP)-1:0] phase;
  logic [1:0] pairs [2];

  vid411_phase #(.GROUP(GROUP)) u_phase (
    .clk(clk), .rst(rst), .blank(in_blank),
    .phase(phase), .first(first), .last(last)
  );

  // one serializer per chroma component: 0 = U, 1 = V
  for (genvar c = 0; c < 2; c++) begin : g_ser
    vid411_chroma_ser #(.C_W(C_W)) u_ser (
      .clk(clk), .rst(rst), .load(first), .adv(!in_blank),
      .smp((c == 0) ? in_u : in_v), .pair(pairs[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst || in_blank) begin
      bus_o       <= BLACK_WORD;
      bus_blank_o <= 1'b1;
    end else begin
      bus_o       <= {in_y, pairs[0], pairs[1]};
      bus_blank_o <= 1'b0;
    end
  end

  assert_black_word_R6: assert property (@(posedge clk) disable iff (rst)
    bus_blank_o |-> (bus_o == BLACK_WORD));
  assert_luma_pass_R1: assert property (@(posedge clk) disable iff (rst)
    !in_blank |=> (bus_o[BW-1 -: Y_W] == $past(in_y)));
endmodule

// File: rtl/vid411_unpacker.sv
module vid411_unpacker #(
  parameter int Y_W = 8,
  parameter int C_W = 8,
  localparam int BW = Y_W + 4,
  localparam int GROUP = C_W / 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [BW-1:0]  in_bus,
  input  logic           in_blank,
  output logic [Y_W-1:0] y_o,
  output logic           y_valid_o,
  output logic [C_W-1:0] u_o,
  output logic [C_W-1:0] v_o,
  output logic           c_valid_o
);
  logic first, last;
  logic [vid411_pkg::ph_width(GROUP)-1:0] phase;
  logic [C_W-1:0] words [2];

  vid411_phase #(.GROUP(GROUP)) u_phase (
    .clk(clk), .rst(rst), .blank(in_blank),
    .phase(phase), .first(first), .last(last)
  );

  for (genvar c = 0; c < 2; c++) begin : g_des
    vid411_chroma_des #(.C_W(C_W)) u_des (
      .clk(clk), .rst(rst), .shift_en(!in_blank),
      .pair(in_bus[3-2*c -: 2]), .word(words[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      y_o       <= '0;
      y_valid_o <= 1'b0;
      u_o       <= '0;
      v_o       <= '0;
      c_valid_o <= 1'b0;
    end else begin
      y_o       <= in_bus[BW-1 -: Y_W];
      y_valid_o <= !in_blank;
      c_valid_o <= last;
      if (last) begin
        u_o <= words[0];
        v_o <= words[1];
      end
    end
  end

  if (GROUP > 1) begin : g_pulse_chk
    assert_cvalid_pulse_R8: assert property (@(posedge clk) disable iff (rst)
      c_valid_o |=> !c_valid_o);
  end
  assert_no_cvalid_after_blank_R9: assert property (@(posedge clk) disable iff (rst)
    in_blank |=> !c_valid_o);
  assert_yvalid_tracks_R7: assert property (@(posedge clk) disable iff (rst)
    in_blank |=> !y_valid_o);
endmodule

// File: rtl/vid411_codec.sv
module vid411_codec #(
  parameter int Y_W = vid411_pkg::DEF_Y_W,
  parameter int C_W = vid411_pkg::DEF_C_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [Y_W-1:0] pk_y,
  input  logic [C_W-1:0] pk_u,
  input  logic [C_W-1:0] pk_v,
  input  logic           pk_blank,
  output logic [Y_W+3:0] pk_bus,
  output logic           pk_bus_blank,
  input  logic [Y_W+3:0] up_bus,
  input  logic           up_blank,
  output logic [Y_W-1:0] up_y,
  output logic           up_y_valid,
  output logic [C_W-1:0] up_u,
  output logic [C_W-1:0] up_v,
  output logic           up_c_valid
);
  vid411_packer #(.Y_W(Y_W), .C_W(C_W)) u_pack (
    .clk(clk), .rst(rst), .in_y(pk_y), .in_u(pk_u), .in_v(pk_v),
    .in_blank(pk_blank), .bus_o(pk_bus), .bus_blank_o(pk_bus_blank)
  );

  vid411_unpacker #(.Y_W(Y_W), .C_W(C_W)) u_unpack (
    .clk(clk), .rst(rst), .in_bus(up_bus), .in_blank(up_blank),
    .y_o(up_y), .y_valid_o(up_y_valid), .u_o(up_u), .v_o(up_v),
    .c_valid_o(up_c_valid)
  );
endmodule

// File: tb/test_vid411_codec.sv
module test_vid411_codec;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] pk_y = '0, pk_u = '0, pk_v = '0;
  logic pk_blank = 1'b1;
  logic [11:0] pk_bus;
  logic pk_bus_blank;
  logic [7:0] up_y, up_u, up_v;
  logic up_y_valid, up_c_valid;

  int checks = 0;
  int errors = 0;

  // model state
  int m_ph = 0;
  logic [7:0] m_u = '0, m_v = '0, sent_u = '0, sent_v = '0;
  logic [11:0] prev_bus = 12'h10A;
  logic prev_blank = 1'b1;
  int d_ph = 0;
  logic [7:0] d_u = '0, d_v = '0;

  always #5 clk = ~clk;

  vid411_codec i_vid411_codec (
    .clk(clk), .rst(rst), .pk_y(pk_y), .pk_u(pk_u), .pk_v(pk_v),
    .pk_blank(pk_blank), .pk_bus(pk_bus), .pk_bus_blank(pk_bus_blank),
    .up_bus(pk_bus), .up_blank(pk_bus_blank), .up_y(up_y),
    .up_y_valid(up_y_valid), .up_u(up_u), .up_v(up_v),
    .up_c_valid(up_c_valid)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] pair_of(input logic [7:0] s, input int ph);
    return s[7-2*ph -: 2];
  endfunction

  task automatic step(input logic [7:0] y, input logic [7:0] u,
                      input logic [7:0] v, input logic b);
    logic [11:0] eb;
    logic ecv;
    @(negedge clk);
    pk_y = y; pk_u = u; pk_v = v; pk_blank = b;
    @(posedge clk);
    #1;
    // unpacker side, from the word present before this edge
    ecv = 1'b0;
    if (prev_blank) begin
      d_ph = 0;
      chk("R7 y_valid", up_y_valid, 0);
    end else begin
      chk("R7 y_valid", up_y_valid, 1);
      chk("R7 y", up_y, prev_bus[11:4]);
      d_u = {d_u[5:0], prev_bus[3:2]};
      d_v = {d_v[5:0], prev_bus[1:0]};
      if (d_ph == 3) begin ecv = 1'b1; d_ph = 0; end
      else d_ph++;
    end
    chk("R8 c_valid", up_c_valid, ecv);
    if (ecv) begin
      chk("R8 u", up_u, d_u);
      chk("R8 v", up_v, d_v);
      chk("R10 u loopback", up_u, sent_u);
      chk("R10 v loopback", up_v, sent_v);
    end
    // packer side
    if (b) begin
      eb = 12'h10A;
      m_ph = 0;
    end else begin
      if (m_ph == 0) begin m_u = u; m_v = v; sent_u = u; sent_v = v; end
      eb = {y, pair_of(m_u, m_ph), pair_of(m_v, m_ph)};
      m_ph = (m_ph + 1) % 4;
    end
    chk("R1 luma", pk_bus[11:4], eb[11:4]);
    chk("R3 chroma lanes", pk_bus[3:0], eb[3:0]);
    chk("R6 bus blank", pk_bus_blank, b);
    prev_bus = eb;
    prev_blank = b;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd411));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    chk("R11 bus", pk_bus, 12'h10A);
    chk("R11 bus blank", pk_bus_blank, 1);
    chk("R11 y_valid", up_y_valid, 0);
    chk("R11 c_valid", up_c_valid, 0);

    step(8'h00, 8'h00, 8'h00, 1'b1);
    chk("R6 black word", pk_bus, 12'h10A);

    // R2: U set only at top, V only at bottom
    step(8'h55, 8'hC0, 8'h03, 1'b0);
    chk("R2 first pair", pk_bus[3:0], 4'hC);
    // R4: chroma inputs change mid-group
    step(8'h66, 8'hFF, 8'hFF, 1'b0);
    chk("R4 mid group", pk_bus[3:0], 4'h0);
    step(8'h77, 8'h3C, 8'h81, 1'b0);
    step(8'h88, 8'hFF, 8'h00, 1'b0);
    chk("R2 last pair", pk_bus[3:0], 4'h3);
    step(8'h99, 8'h12, 8'h34, 1'b1);
    chk("R4 u kept", up_u, 8'hC0);
    chk("R4 v kept", up_v, 8'h03);

    // R5 / R9: group cut by blanking after two clocks
    step(8'h10, 8'hAA, 8'h55, 1'b0);
    step(8'h11, 8'hAA, 8'h55, 1'b0);
    step(8'h12, 8'h00, 8'h00, 1'b1);
    chk("R9 no strobe", up_c_valid, 0);
    step(8'h13, 8'h40, 8'h80, 1'b0);
    chk("R5 restart pair", pk_bus[3:0], 4'b0110);
    chk("R9 no strobe", up_c_valid, 0);
    step(8'h14, 8'h00, 8'h00, 1'b0);
    chk("R9 no strobe", up_c_valid, 0);
    step(8'h15, 8'h00, 8'h00, 1'b0);
    step(8'h16, 8'h00, 8'h00, 1'b0);
    step(8'h17, 8'h00, 8'h00, 1'b0);
    chk("R10 after restart", up_u, 8'h40);

    // random stream with sparse blanking
    for (int n = 0; n < 3000; n++) begin
      step(8'($urandom), 8'($urandom), 8'($urandom), ($urandom % 16) == 0);
    end
    step(8'h00, 8'h00, 8'h00, 1'b1);
    step(8'h00, 8'h00, 8'h00, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule